// File: doc/BRIEF.md
# Rational-Ratio Clock-Enable Phase-Locked Loop

This block is an all-digital phase-locked loop that lives entirely in one fast system clock domain. It takes a slower reference clock as a plain level input and produces a train of one-cycle enable pulses whose long-term rate is N/(N-1) times the reference frequency. A second output is the same train with one pulse out of every N removed. That gapped strobe is both the loop's feedback and the read strobe for a downstream FIFO. Because the loop locks the gapped strobe to the reference, data leaves the FIFO at the rate it arrives, and the fill level stays constant.

The reference passes through a synchronizer and a rising-edge detector. It then drives a signed up/down phase counter, which the gapped strobe counts down. A proportional-plus-integral filter adds the scaled counter value and a scaled running sum of it to a nominal centre step. An accumulator adds that step every cycle, and its carry is the enable pulse.

Both outputs are bare strobes with no handshake. The consumer must act on every cycle in which a strobe is high; there is no back-pressure path.

Top module: `ratio_pll`

## Requirements
- R1: A synchronous active-high reset clears the phase counter, integrator, accumulator, gap counter and synchronizer. `en_o` and `rd_o` stay low while `rst` is high and in the first cycle after it falls, whatever the reference does.
- R2: The reference passes through two synchronizer flops and then a rising-edge detector. A detected rising edge adds one to the signed phase counter. An `rd_o` pulse subtracts one. A cycle with both or neither leaves the counter unchanged. The counter saturates at its signed limits.
- R3: The step is registered. Its value is CENTER + counter·2^KP_SHIFT + (integrator >>> KI_SHIFT), clamped to [0, 2^W-1]. When the counter and integrator are zero the step equals CENTER. So, after reset with the reference idle, the first `en_o` is high in the cycle after the 2^W/CENTER-th clock edge (edge 32 with the defaults).
- R4: Each cycle the integrator adds the current phase-counter value and saturates at its signed limits. This lets the phase error settle at any reference rate in range.
- R5: The W-bit accumulator adds the step each cycle and keeps the remainder. `en_o` is high for exactly the cycle after an edge on which the accumulator carried out.
- R6: Number the `en_o` pulses from 0 after reset. The pulse whose index modulo N equals N-1 does not appear on `rd_o`; every other pulse does. `rd_o` is never high while `en_o` is low.
- R7: Take a reference with a period of 33 to 50 system cycles (defaults). After 35000 cycles from reset, the `rd_o` count over a 16000-cycle window is within 6 of the count of reference rising edges.
- R8: In the same window, (N-1) times the `en_o` count is within 7·N of N times the reference edge count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every register of the block uses its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ref_clk_i | input | 1 | Reference clock, asynchronous to `clk`, treated as a level |
| en_o | output | 1 | Oscillator enable, one cycle per accumulator carry |
| rd_o | output | 1 | Gapped strobe: N-1 of every N enables; feedback and FIFO read |

## Verification
The assertions guard the per-cycle rules on every cycle:
- how the phase counter moves on up, down, both and neither events, including saturation;
- that the integrator adds the error exactly when far from its limits;
- that a zero error and integral yield the centre step, and a steady filter input yields a steady step;
- that the accumulator falls only on a carry;
- that `rd_o` is drawn from `en_o` and restarts the gap cycle after each dropped pulse.

Only the bench's scenarios can show the closed-loop results. These are the exact timing of the first free-running pulse, the gap pattern over whole runs, and that the loop locks at three reference ratios. Lock means the gapped strobe count tracks the reference edge count, and the enable rate lands on N/(N-1) of the reference.

// File: rtl/rpll_pkg.sv
package rpll_pkg;

  // Event seen by the phase counter in one system cycle.
  typedef enum logic [1:0] {
    PD_HOLD = 2'd0,
    PD_UP   = 2'd1,
    PD_DOWN = 2'd2
  } pd_ev_e;

endpackage

// File: rtl/rpll_phase_det.sv
module rpll_phase_det
  import rpll_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int EW          = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ref_i,
  input  logic                 fb_i,
  output logic signed [EW-1:0] err_o
);

  localparam logic signed [EW-1:0] ERR_MAX = {1'b0, {(EW-1){1'b1}}};
  localparam logic signed [EW-1:0] ERR_MIN = {1'b1, {(EW-1){1'b0}}};
  localparam logic signed [EW-1:0] ERR_ONE = EW'(1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ref_last_q;
  logic                   ref_rise;
  pd_ev_e                 ev;
  logic signed [EW-1:0]   err_q;

  // Synchronizer chain, one flop per stage.
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sync_q[0] <= 1'b0;
        else     sync_q[0] <= ref_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) sync_q[g] <= 1'b0;
        else     sync_q[g] <= sync_q[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ref_last_q <= 1'b0;
    else     ref_last_q <= sync_q[SYNC_STAGES-1];
  end

  assign ref_rise = sync_q[SYNC_STAGES-1] & ~ref_last_q;

  always_comb begin
    case ({ref_rise, fb_i})
      2'b10:   ev = PD_UP;
      2'b01:   ev = PD_DOWN;
      default: ev = PD_HOLD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= '0;
    end else begin
      case (ev)
        PD_UP:   if (err_q != ERR_MAX) err_q <= err_q + ERR_ONE;
        PD_DOWN: if (err_q != ERR_MIN) err_q <= err_q - ERR_ONE;
        default: ;
      endcase
    end
  end

  assign err_o = err_q;

  assert_up_R2: assert property (@(posedge clk) disable iff (rst)
    (ref_rise && !fb_i && err_q != ERR_MAX) |=> err_q == $past(err_q) + ERR_ONE);

  assert_down_R2: assert property (@(posedge clk) disable iff (rst)
    (fb_i && !ref_rise && err_q != ERR_MIN) |=> err_q == $past(err_q) - ERR_ONE);

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (ref_rise == fb_i) |=> $stable(err_q));

  assert_sat_R2: assert property (@(posedge clk) disable iff (rst)
    (err_q == ERR_MAX && ref_rise && !fb_i) |=> err_q == ERR_MAX);

endmodule

// File: rtl/rpll_pi_filter.sv
module rpll_pi_filter #(
  parameter int W        = 16,
  parameter int EW       = 12,
  parameter int IW       = 24,
  parameter int KP_SHIFT = 6,
  parameter int KI_SHIFT = 7,
  parameter int CENTER   = 2048
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [EW-1:0] err_i,
  output logic        [W-1:0]  step_o
);

  localparam int SW = ((IW > W) ? IW : W) + EW + KP_SHIFT + 2;

  localparam logic signed [IW:0]   I_MAX    = {2'b00, {(IW-1){1'b1}}};
  localparam logic signed [IW:0]   I_MIN    = {2'b11, {(IW-1){1'b0}}};
  localparam logic signed [SW-1:0] STEP_C   = SW'(CENTER);
  localparam logic signed [SW-1:0] STEP_TOP = SW'((64'd1 << W) - 64'd1);
  localparam logic        [W-1:0]  STEP_RST = W'(CENTER);

  logic signed [IW-1:0] integ_q;
  logic signed [IW-1:0] integ_d;
  logic signed [IW:0]   err_x;
  logic signed [IW:0]   i_sum;
  logic signed [SW-1:0] p_term;
  logic signed [SW-1:0] i_term;
  logic signed [SW-1:0] s_sum;
  logic        [W-1:0]  step_d;
  logic        [W-1:0]  step_q;

  // Saturating integrator.
  always_comb begin
    err_x = $signed({{(IW+1-EW){err_i[EW-1]}}, err_i});
    i_sum = $signed({integ_q[IW-1], integ_q}) + err_x;
    if (i_sum > I_MAX)      integ_d = I_MAX[IW-1:0];
    else if (i_sum < I_MIN) integ_d = I_MIN[IW-1:0];
    else                    integ_d = i_sum[IW-1:0];
  end

  // Proportional plus scaled integral plus centre, clamped to the step range.
  always_comb begin
    p_term = $signed({{(SW-EW){err_i[EW-1]}}, err_i}) <<< KP_SHIFT;
    i_term = $signed({{(SW-IW){integ_q[IW-1]}}, integ_q}) >>> KI_SHIFT;
    s_sum  = STEP_C + p_term + i_term;
    if (s_sum[SW-1])           step_d = '0;
    else if (s_sum > STEP_TOP) step_d = '1;
    else                       step_d = s_sum[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      integ_q <= '0;
      step_q  <= STEP_RST;
    end else begin
      integ_q <= integ_d;
      step_q  <= step_d;
    end
  end

  assign step_o = step_q;

  assert_integ_R4: assert property (@(posedge clk) disable iff (rst)
    (integ_q[IW-1] == integ_q[IW-2])
      |=> integ_q == $past(integ_q) + $past(err_x[IW-1:0]));

  assert_center_R3: assert property (@(posedge clk) disable iff (rst)
    (err_i == '0 && integ_q == '0) |=> step_q == STEP_RST);

  assert_steady_R3: assert property (@(posedge clk) disable iff (rst)
    ($stable(err_i) && $stable(integ_q)) |=> $stable(step_q));

endmodule

// File: rtl/rpll_nco.sv
module rpll_nco #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] step_i,
  output logic         en_o
);

  logic [W-1:0] acc_q;
  logic [W:0]   sum;
  logic         en_q;

  assign sum = {1'b0, acc_q} + {1'b0, step_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      en_q  <= 1'b0;
    end else begin
      acc_q <= sum[W-1:0];
      en_q  <= sum[W];
    end
  end

  assign en_o = en_q;

  assert_carry_R5: assert property (@(posedge clk) disable iff (rst)
    en_q |-> acc_q < $past(acc_q));

  assert_rise_R5: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> acc_q >= $past(acc_q));

endmodule

// File: rtl/rpll_gap.sv
module rpll_gap #(
  parameter int N = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  output logic rd_o
);

  localparam int           GW   = (N > 1) ? $clog2(N) : 1;
  localparam logic [GW-1:0] LAST = GW'(N - 1);
  localparam logic [GW-1:0] ONE  = GW'(1);

  logic [GW-1:0] gcnt_q;
  logic [GW-1:0] gcnt_nx;

  // Power-of-two N wraps for free; other N needs an explicit wrap.
  if ((N & (N - 1)) == 0) begin : g_pow2
    assign gcnt_nx = gcnt_q + ONE;
  end else begin : g_wrap
    assign gcnt_nx = (gcnt_q == LAST) ? '0 : gcnt_q + ONE;
  end

  always_ff @(posedge clk) begin
    if (rst)       gcnt_q <= '0;
    else if (en_i) gcnt_q <= gcnt_nx;
  end

  assign rd_o = en_i && (gcnt_q != LAST);

  assert_rd_from_en_R6: assert property (@(posedge clk) disable iff (rst)
    rd_o |-> en_i);

  assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
    (en_i && !rd_o) |=> gcnt_q == '0);

endmodule

// File: rtl/ratio_pll.sv
module ratio_pll #(
  parameter int N           = 4,
  parameter int W           = 16,
  parameter int EW          = 12,
  parameter int IW          = 24,
  parameter int KP_SHIFT    = 6,
  parameter int KI_SHIFT    = 7,
  parameter int CENTER      = 2048,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_clk_i,
  output logic en_o,
  output logic rd_o
);

  logic signed [EW-1:0] err;
  logic        [W-1:0]  step;
  logic                 en;
  logic                 rd;

  rpll_phase_det #(.SYNC_STAGES(SYNC_STAGES), .EW(EW)) u_pd (
    .clk   (clk),
    .rst   (rst),
    .ref_i (ref_clk_i),
    .fb_i  (rd),
    .err_o (err)
  );

  rpll_pi_filter #(
    .W(W), .EW(EW), .IW(IW),
    .KP_SHIFT(KP_SHIFT), .KI_SHIFT(KI_SHIFT), .CENTER(CENTER)
  ) u_lf (
    .clk    (clk),
    .rst    (rst),
    .err_i  (err),
    .step_o (step)
  );

  rpll_nco #(.W(W)) u_osc (
    .clk    (clk),
    .rst    (rst),
    .step_i (step),
    .en_o   (en)
  );

  rpll_gap #(.N(N)) u_gap (
    .clk  (clk),
    .rst  (rst),
    .en_i (en),
    .rd_o (rd)
  );

  assign en_o = en;
  assign rd_o = rd;

endmodule

// File: tb/ratio_pll_tb.sv
module ratio_pll_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 4;
  localparam int FIRST_EDGE = 32;     // 2^16 / 2048
  localparam int SETTLE     = 35000;
  localparam int WINDOW     = 16000;
  localparam int WATCHDOG   = 195000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_clk = 1'b0;
  logic en_o, rd_o;

  int checks = 0, errors = 0;
  int ref_per = 0, ph = 0;
  int n_en = 0, n_rd = 0, n_ref = 0, gap_bad = 0, pulse_idx = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ratio_pll u_dut (
    .clk       (clk),
    .rst       (rst),
    .ref_clk_i (ref_clk),
    .en_o      (en_o),
    .rd_o      (rd_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_counts();
    n_en = 0; n_rd = 0; n_ref = 0; gap_bad = 0; pulse_idx = 0;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Reference generator and output monitor, both on the falling edge.
  always @(negedge clk) begin
    bit nxt;
    if (ref_per == 0) begin
      ref_clk = 1'b0;
      ph = 0;
    end else begin
      ph = (ph + 1 >= ref_per) ? 0 : ph + 1;
      nxt = (ph < ref_per / 2);
      if (nxt && !ref_clk) n_ref++;
      ref_clk = nxt;
    end
    if (!rst) begin
      if (en_o) begin
        if (rd_o != ((pulse_idx % N) != N - 1)) gap_bad++;
        pulse_idx++;
        n_en++;
      end else if (rd_o) begin
        gap_bad++;
      end
      if (rd_o) n_rd++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int bad;
    int s_en, s_rd, s_ref, d_en, d_rd, d_ref, diff;
    int pers [3] = '{33, 40, 50};

    // R1: outputs held low through reset with the reference toggling.
    rst = 1'b1;
    ref_per = 40;
    bad = 0;
    for (int k = 0; k < 30; k++) begin
      cycles(1);
      if (en_o || rd_o) bad++;
    end
    chk(bad == 0, "R1 outputs during reset", bad, 0);

    // R3 / R5: free-running from centre step with the reference idle.
    ref_per = 0;
    cycles(3);
    rst = 1'b0;
    clear_counts();
    bad = 0;
    for (int k = 1; k <= FIRST_EDGE + 1; k++) begin
      cycles(1);
      if (k == 1) chk(!en_o && !rd_o, "R1 first cycle after reset", en_o, 0);
      if (en_o != (k == FIRST_EDGE)) bad++;
      if (k == FIRST_EDGE) chk(rd_o == 1'b1, "R6 pulse index 0 passes", rd_o, 1);
    end
    chk(bad == 0, "R3 R5 first carry timing", bad, 0);

    cycles(3000);
    chk(n_en >= 2 * N, "R6 enough pulses for gap check", n_en, 2 * N);
    chk(gap_bad == 0, "R6 gap pattern with idle reference", gap_bad, 0);

    // R7 / R8 / R4 / R2: closed-loop lock at several reference ratios.
    foreach (pers[i]) begin
      rst = 1'b1;
      cycles(5);
      ref_per = pers[i];
      rst = 1'b0;
      clear_counts();
      cycles(SETTLE);
      s_en = n_en; s_rd = n_rd; s_ref = n_ref;
      cycles(WINDOW);
      d_en = n_en - s_en; d_rd = n_rd - s_rd; d_ref = n_ref - s_ref;
      diff = d_rd - d_ref;
      if (diff < 0) diff = -diff;
      // Counter tracking (R2) with integral action (R4) drives the error to zero.
      chk(diff <= 6, $sformatf("R7 lock period %0d (R2 R4)", pers[i]), d_rd, d_ref);
      diff = (N - 1) * d_en - N * d_ref;
      if (diff < 0) diff = -diff;
      chk(diff <= 7 * N, $sformatf("R8 enable ratio period %0d", pers[i]),
          (N - 1) * d_en, N * d_ref);
      chk(gap_bad == 0, $sformatf("R6 gap pattern period %0d", pers[i]), gap_bad, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule